// File: doc/BRIEF.md
# Pseudoinstruction Alias Recognizer

This block sorts 32-bit base-integer and control-register instruction words into assembler shorthand forms, for use by disassembly and trace tools that want to print the short mnemonic. The opcode, funct3 and funct7 fields are decoded first to name the base instruction. Then a priority-ordered rule set for that instruction tests register indices and immediate values. The most specific rule is listed first, so it wins.

Words arrive on a valid/ready stream. Results leave on a second valid/ready stream one cycle later, as a 5-bit alias code and a match flag. The single output register accepts a new word whenever it is empty or its content is being taken in the same cycle. While the consumer holds ready low, a full register blocks the input and keeps its content unchanged. A word that names no known base instruction, or that satisfies no rule, still produces a result: code 0 with the flag low.

Top module: `alias_recognizer`

## Requirements
- R1: A word accepted (in_valid and in_ready high at a clock edge) gives its result on out_valid/out_alias/out_match right after that edge. out_valid falls after an edge where the result is taken and no new word arrives. Synchronous reset clears out_valid.
- R2: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the output holds its code and flag unchanged across the edge.
- R3: out_match is 1 exactly when out_alias is nonzero. Fields sit at these bit positions: opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20], funct7 [31:25], I-immediate [31:20], fence predecessor set [27:24], fence successor set [23:20].
- R4: For addi (opcode 0010011, funct3 000):
  - rd=0, rs1=0 and imm=0 gives nop (code 1).
  - Otherwise, imm=0 gives mv (code 2).
- R5: Immediate aliases on opcode 0010011:
  - sltiu (funct3 011) with imm=1 gives seqz (code 3).
  - xori (funct3 100) with imm=0xFFF gives not (code 4).
  - andi (funct3 111) with imm=0x0FF gives zext.b (code 5).
  - addiw (opcode 0011011, funct3 000) with imm=0 gives sext.w (code 6).
  - Any other immediate value gives code 0.
- R6: For fence (opcode 0001111, funct3 000):
  - Predecessor 0001, successor 0000, rd=0 and rs1=0 gives pause (code 7).
  - Predecessor 1111 with successor 1111 gives the full fence (code 8).
- R7: For jalr (opcode 1100111), rd=0 with rs1=1 and imm=0 gives ret (code 9); any other jalr with rd=0 gives jr (code 10). For jal (opcode 1101111), rd=0 gives j (code 11) and rd=1 gives the single-operand jal (code 12).
- R8: Branches (opcode 1100011), where a rule on rs2=0 beats a rule on rs1=0:
  - beq (funct3 000) with rs2=0 gives beqz (13).
  - bne (001) with rs2=0 gives bnez (14).
  - blt (100) with rs2=0 gives bltz (15), and with rs1=0 gives bgtz (16).
  - bge (101) with rs1=0 gives blez (17), and with rs2=0 gives bgez (18).
- R9: Register-register aliases, all requiring the exact funct7:
  - sub (opcode 0110011, funct7 0100000, funct3 000) with rs1=0 gives neg (19).
  - subw (opcode 0111011, same funct7/funct3) with rs1=0 gives negw (20).
  - slt (funct7 0, funct3 010) with rs2=0 gives sltz (21), and with rs1=0 gives sgtz (22).
  - sltu (funct3 011) with rs1=0 gives snez (23).
- R10: Control-register words (opcode 1110011):
  - csrrs (funct3 010) with rs1=0 gives csrr (24) whatever rd is.
  - Otherwise, rd=0 gives the write-only form: csrrw/001 gives 25, csrrs/010 gives 26, csrrc/011 gives 27, csrrwi/101 gives 28, csrrsi/110 gives 29, csrrci/111 gives 30.
- R11: Unknown opcodes, unlisted funct3/funct7 combinations, and listed instructions that satisfy no rule give code 0 with out_match low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_alias | output | 5 | Alias code (0 = none) |
| out_match | output | 1 | Some alias rule matched |

## Verification
The hardest situations to reach from the ports are the overlapping rules: words that satisfy two rules at once. Examples are addi with every field zero, csrrs with both rd and rs1 zero, and blt, bge or slt with both sources zero. The stimulus builds these words field by field and checks that the more specific or higher-priority code appears. A stall, in which a second word waits while the consumer withholds ready, is forced by dropping out_ready for exactly one cycle. The test then confirms that the held result and the blocked input both survive.

// File: rtl/alias_rec_pkg.sv
package alias_rec_pkg;

  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 12;
  localparam int SET_W  = 4;
  localparam int CODE_W = 5;

  localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
  localparam logic [6:0] OPC_OPIMM32 = 7'b0011011;
  localparam logic [6:0] OPC_OP      = 7'b0110011;
  localparam logic [6:0] OPC_OP32    = 7'b0111011;
  localparam logic [6:0] OPC_BRANCH  = 7'b1100011;
  localparam logic [6:0] OPC_JAL     = 7'b1101111;
  localparam logic [6:0] OPC_JALR    = 7'b1100111;
  localparam logic [6:0] OPC_MISC    = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM  = 7'b1110011;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [CODE_W-1:0] {
    AL_NONE   = 5'd0,  AL_NOP    = 5'd1,  AL_MV     = 5'd2,  AL_SEQZ   = 5'd3,
    AL_NOT    = 5'd4,  AL_ZEXTB  = 5'd5,  AL_SEXTW  = 5'd6,  AL_PAUSE  = 5'd7,
    AL_FENCE  = 5'd8,  AL_RET    = 5'd9,  AL_JR     = 5'd10, AL_J      = 5'd11,
    AL_JALRA  = 5'd12, AL_BEQZ   = 5'd13, AL_BNEZ   = 5'd14, AL_BLTZ   = 5'd15,
    AL_BGTZ   = 5'd16, AL_BLEZ   = 5'd17, AL_BGEZ   = 5'd18, AL_NEG    = 5'd19,
    AL_NEGW   = 5'd20, AL_SLTZ   = 5'd21, AL_SGTZ   = 5'd22, AL_SNEZ   = 5'd23,
    AL_CSRR   = 5'd24, AL_CSRW   = 5'd25, AL_CSRS   = 5'd26, AL_CSRC   = 5'd27,
    AL_CSRWI  = 5'd28, AL_CSRSI  = 5'd29, AL_CSRCI  = 5'd30
  } alias_e;

  typedef enum logic [4:0] {
    B_NONE, B_ADDI, B_SLTIU, B_XORI, B_ANDI, B_ADDIW, B_SUB, B_SUBW,
    B_SLT, B_SLTU, B_BEQ, B_BNE, B_BLT, B_BGE, B_JAL, B_JALR, B_FENCE,
    B_CSRRW, B_CSRRS, B_CSRRC, B_CSRRWI, B_CSRRSI, B_CSRRCI
  } base_e;

  typedef struct packed {
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [IMM_W-1:0] imm;
    logic [SET_W-1:0] pred;
    logic [SET_W-1:0] succ;
  } fields_t;

endpackage

// File: rtl/alias_fields.sv
module alias_fields
  import alias_rec_pkg::*;
#(
  parameter bit HAS_WORD_OPS = 1'b1
) (
  input  logic [INSN_W-1:0] insn,
  output fields_t           flds,
  output base_e             base
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  base_e      base_main;
  base_e      base_word;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign f7  = insn[31:25];

  assign flds.rd   = insn[11:7];
  assign flds.rs1  = insn[19:15];
  assign flds.rs2  = insn[24:20];
  assign flds.imm  = insn[31:20];
  assign flds.pred = insn[27:24];
  assign flds.succ = insn[23:20];

  always_comb begin
    base_main = B_NONE;
    unique case (opc)
      OPC_OPIMM: begin
        case (f3)
          3'b000:  base_main = B_ADDI;
          3'b011:  base_main = B_SLTIU;
          3'b100:  base_main = B_XORI;
          3'b111:  base_main = B_ANDI;
          default: base_main = B_NONE;
        endcase
      end
      OPC_OP: begin
        if (f7 == F7_ALT && f3 == 3'b000)       base_main = B_SUB;
        else if (f7 == F7_BASE && f3 == 3'b010) base_main = B_SLT;
        else if (f7 == F7_BASE && f3 == 3'b011) base_main = B_SLTU;
      end
      OPC_BRANCH: begin
        case (f3)
          3'b000:  base_main = B_BEQ;
          3'b001:  base_main = B_BNE;
          3'b100:  base_main = B_BLT;
          3'b101:  base_main = B_BGE;
          default: base_main = B_NONE;
        endcase
      end
      OPC_JAL:  base_main = B_JAL;
      OPC_JALR: if (f3 == 3'b000) base_main = B_JALR;
      OPC_MISC: if (f3 == 3'b000) base_main = B_FENCE;
      OPC_SYSTEM: begin
        case (f3)
          3'b001:  base_main = B_CSRRW;
          3'b010:  base_main = B_CSRRS;
          3'b011:  base_main = B_CSRRC;
          3'b101:  base_main = B_CSRRWI;
          3'b110:  base_main = B_CSRRSI;
          3'b111:  base_main = B_CSRRCI;
          default: base_main = B_NONE;
        endcase
      end
      default: base_main = B_NONE;
    endcase
  end

  generate
    if (HAS_WORD_OPS) begin : g_word
      always_comb begin
        base_word = B_NONE;
        if (opc == OPC_OPIMM32 && f3 == 3'b000)
          base_word = B_ADDIW;
        else if (opc == OPC_OP32 && f7 == F7_ALT && f3 == 3'b000)
          base_word = B_SUBW;
      end
    end else begin : g_noword
      assign base_word = B_NONE;
    end
  endgenerate

  assign base = (base_word != B_NONE) ? base_word : base_main;

endmodule

// File: rtl/alias_rules.sv
module alias_rules
  import alias_rec_pkg::*;
(
  input  base_e   base,
  input  fields_t flds,
  output alias_e  code,
  output logic    hit
);
  localparam logic [REG_W-1:0] RA_IDX = REG_W'(1);

  logic rd_z, rs1_z, rs2_z, imm_z, rd_ra, rs1_ra;

  assign rd_z   = (flds.rd  == '0);
  assign rs1_z  = (flds.rs1 == '0);
  assign rs2_z  = (flds.rs2 == '0);
  assign imm_z  = (flds.imm == '0);
  assign rd_ra  = (flds.rd  == RA_IDX);
  assign rs1_ra = (flds.rs1 == RA_IDX);

  always_comb begin
    code = AL_NONE;
    hit  = 1'b0;
    case (base)
      B_ADDI: begin
        if (rd_z && rs1_z && imm_z) begin code = AL_NOP; hit = 1'b1; end
        else if (imm_z)             begin code = AL_MV;  hit = 1'b1; end
      end
      B_SLTIU: if (flds.imm == IMM_W'(1)) begin code = AL_SEQZ; hit = 1'b1; end
      B_XORI:  if (&flds.imm)             begin code = AL_NOT;  hit = 1'b1; end
      B_ANDI:  if (flds.imm == IMM_W'(255)) begin code = AL_ZEXTB; hit = 1'b1; end
      B_ADDIW: if (imm_z)                 begin code = AL_SEXTW; hit = 1'b1; end
      B_FENCE: begin
        if (flds.pred == 4'b0001 && flds.succ == 4'b0000 && rd_z && rs1_z) begin
          code = AL_PAUSE; hit = 1'b1;
        end else if (&flds.pred && &flds.succ) begin
          code = AL_FENCE; hit = 1'b1;
        end
      end
      B_JALR: begin
        if (rd_z && rs1_ra && imm_z) begin code = AL_RET; hit = 1'b1; end
        else if (rd_z)               begin code = AL_JR;  hit = 1'b1; end
      end
      B_JAL: begin
        if (rd_z)       begin code = AL_J;     hit = 1'b1; end
        else if (rd_ra) begin code = AL_JALRA; hit = 1'b1; end
      end
      B_BEQ: if (rs2_z) begin code = AL_BEQZ; hit = 1'b1; end
      B_BNE: if (rs2_z) begin code = AL_BNEZ; hit = 1'b1; end
      B_BLT: begin
        if (rs2_z)      begin code = AL_BLTZ; hit = 1'b1; end
        else if (rs1_z) begin code = AL_BGTZ; hit = 1'b1; end
      end
      B_BGE: begin
        if (rs2_z)      begin code = AL_BGEZ; hit = 1'b1; end
        else if (rs1_z) begin code = AL_BLEZ; hit = 1'b1; end
      end
      B_SUB:  if (rs1_z) begin code = AL_NEG;  hit = 1'b1; end
      B_SUBW: if (rs1_z) begin code = AL_NEGW; hit = 1'b1; end
      B_SLT: begin
        if (rs2_z)      begin code = AL_SLTZ; hit = 1'b1; end
        else if (rs1_z) begin code = AL_SGTZ; hit = 1'b1; end
      end
      B_SLTU: if (rs1_z) begin code = AL_SNEZ; hit = 1'b1; end
      B_CSRRS: begin
        if (rs1_z)     begin code = AL_CSRR; hit = 1'b1; end
        else if (rd_z) begin code = AL_CSRS; hit = 1'b1; end
      end
      B_CSRRW:  if (rd_z) begin code = AL_CSRW;  hit = 1'b1; end
      B_CSRRC:  if (rd_z) begin code = AL_CSRC;  hit = 1'b1; end
      B_CSRRWI: if (rd_z) begin code = AL_CSRWI; hit = 1'b1; end
      B_CSRRSI: if (rd_z) begin code = AL_CSRSI; hit = 1'b1; end
      B_CSRRCI: if (rd_z) begin code = AL_CSRCI; hit = 1'b1; end
      default: begin
        code = AL_NONE;
        hit  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alias_stage.sv
module alias_stage
  import alias_rec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   up_valid,
  output logic   up_ready,
  input  alias_e up_code,
  input  logic   up_hit,
  output logic   dn_valid,
  input  logic   dn_ready,
  output alias_e dn_code,
  output logic   dn_hit
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_code  <= AL_NONE;
      dn_hit   <= 1'b0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) begin
        dn_code <= up_code;
        dn_hit  <= up_hit;
      end
    end
  end

endmodule

// File: rtl/alias_recognizer.sv
module alias_recognizer
  import alias_rec_pkg::*;
#(
  parameter bit HAS_WORD_OPS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_alias,
  output logic              out_match
);
  fields_t flds;
  base_e   base;
  alias_e  code_c;
  logic    hit_c;
  alias_e  code_q;

  alias_fields #(.HAS_WORD_OPS(HAS_WORD_OPS)) u_fields (
    .insn (in_insn),
    .flds (flds),
    .base (base)
  );

  alias_rules u_rules (
    .base (base),
    .flds (flds),
    .code (code_c),
    .hit  (hit_c)
  );

  alias_stage u_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_code  (code_c),
    .up_hit   (hit_c),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_code  (code_q),
    .dn_hit   (out_match)
  );

  assign out_alias = code_q;

endmodule

// File: rtl/alias_recognizer_chk.sv
module alias_recognizer_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_insn,
  input logic        out_valid,
  input logic        out_ready,
  input logic [4:0]  out_alias,
  input logic        out_match
);
  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_alias) && $stable(out_match)); // R2

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R2

  AST_FLAG_AGREES: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_match == (out_alias != 5'd0))); // R3

  AST_NOP_FIRST: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_insn == 32'h0000_0013 |=> out_alias == 5'd1); // R4

  AST_CSRR_FIRST: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_insn[6:0] == 7'b1110011 && in_insn[14:12] == 3'b010
    && in_insn[19:15] == 5'd0 |=> out_alias == 5'd24); // R10

endmodule

bind alias_recognizer alias_recognizer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_insn   (in_insn),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_alias (out_alias),
  .out_match (out_match)
);

// File: tb/tb_alias_recognizer.sv
`timescale 1ns/1ps
module tb_alias_recognizer;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_insn;
  logic        out_valid;
  logic        out_ready;
  logic [4:0]  out_alias;
  logic        out_match;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  alias_recognizer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .out_valid(out_valid), .out_ready(out_ready),
    .out_alias(out_alias), .out_match(out_match)
  );

  function automatic [31:0] ei(input [11:0] imm, input [4:0] rs1, input [2:0] f3,
                               input [4:0] rd, input [6:0] op);
    ei = {imm, rs1, f3, rd, op};
  endfunction
  function automatic [31:0] er(input [6:0] f7, input [4:0] rs2, input [4:0] rs1,
                               input [2:0] f3, input [4:0] rd, input [6:0] op);
    er = {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic [31:0] eb(input [4:0] rs2, input [4:0] rs1, input [2:0] f3);
    eb = {7'b0000000, rs2, rs1, f3, 5'b01000, 7'b1100011};
  endfunction
  function automatic [31:0] ejal(input [4:0] rd);
    ejal = {20'h00800, rd, 7'b1101111};
  endfunction
  function automatic [31:0] efen(input [3:0] p, input [3:0] s, input [4:0] rs1, input [4:0] rd);
    efen = {4'b0000, p, s, rs1, 3'b000, rd, 7'b0001111};
  endfunction
  function automatic [31:0] ecsr(input [4:0] rs1, input [2:0] f3, input [4:0] rd);
    ecsr = {12'h300, rs1, f3, rd, 7'b1110011};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one word in, result checked at the following falling edge
  task automatic send(input string req, input [31:0] w, input int exp_code);
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = w;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, out_valid, 1);
    check({req, " code"},  out_alias, exp_code);
    check({req, " match"}, out_match, (exp_code != 0) ? 1 : 0);
  endtask

  task automatic t_reset();
    check("R1 reset valid", out_valid, 0);
    check("R2 reset ready", in_ready, 1);
  endtask

  task automatic t_addi();
    send("R4 nop",         32'h0000_0013, 1);
    send("R4 mv",          ei(12'h000, 5'd7, 3'b000, 5'd5, 7'b0010011), 2);
    send("R4 mv rd0",      ei(12'h000, 5'd3, 3'b000, 5'd0, 7'b0010011), 2);
    send("R4 mv rs1 0",    ei(12'h000, 5'd0, 3'b000, 5'd4, 7'b0010011), 2);
    send("R3 addi plain",  ei(12'h001, 5'd7, 3'b000, 5'd5, 7'b0010011), 0);
  endtask

  task automatic t_imm();
    send("R5 seqz",        ei(12'h001, 5'd2, 3'b011, 5'd3, 7'b0010011), 3);
    send("R5 sltiu 2",     ei(12'h002, 5'd2, 3'b011, 5'd3, 7'b0010011), 0);
    send("R5 not",         ei(12'hFFF, 5'd2, 3'b100, 5'd3, 7'b0010011), 4);
    send("R5 xori 7ff",    ei(12'h7FF, 5'd2, 3'b100, 5'd3, 7'b0010011), 0);
    send("R5 zext.b",      ei(12'h0FF, 5'd2, 3'b111, 5'd3, 7'b0010011), 5);
    send("R5 andi 1ff",    ei(12'h1FF, 5'd2, 3'b111, 5'd3, 7'b0010011), 0);
    send("R5 sext.w",      ei(12'h000, 5'd2, 3'b000, 5'd3, 7'b0011011), 6);
    send("R5 addiw 1",     ei(12'h001, 5'd2, 3'b000, 5'd3, 7'b0011011), 0);
  endtask

  task automatic t_fence();
    send("R6 pause",       efen(4'b0001, 4'b0000, 5'd0, 5'd0), 7);
    send("R6 pause rd3",   efen(4'b0001, 4'b0000, 5'd0, 5'd3), 0);
    send("R6 full fence",  efen(4'b1111, 4'b1111, 5'd0, 5'd0), 8);
    send("R6 partial",     efen(4'b1111, 4'b1110, 5'd0, 5'd0), 0);
  endtask

  task automatic t_jump();
    send("R7 ret",         ei(12'h000, 5'd1, 3'b000, 5'd0, 7'b1100111), 9);
    send("R7 jr imm4",     ei(12'h004, 5'd1, 3'b000, 5'd0, 7'b1100111), 10);
    send("R7 jr x5",       ei(12'h000, 5'd5, 3'b000, 5'd0, 7'b1100111), 10);
    send("R7 jalr rd1",    ei(12'h000, 5'd5, 3'b000, 5'd1, 7'b1100111), 0);
    send("R7 j",           ejal(5'd0), 11);
    send("R7 jal ra",      ejal(5'd1), 12);
    send("R7 jal rd5",     ejal(5'd5), 0);
  endtask

  task automatic t_branch();
    send("R8 beqz",        eb(5'd0, 5'd4, 3'b000), 13);
    send("R8 beq rs1 0",   eb(5'd3, 5'd0, 3'b000), 0);
    send("R8 bnez",        eb(5'd0, 5'd4, 3'b001), 14);
    send("R8 bltz",        eb(5'd0, 5'd4, 3'b100), 15);
    send("R8 bgtz",        eb(5'd4, 5'd0, 3'b100), 16);
    send("R8 blt both 0",  eb(5'd0, 5'd0, 3'b100), 15);
    send("R8 blez",        eb(5'd4, 5'd0, 3'b101), 17);
    send("R8 bgez",        eb(5'd0, 5'd4, 3'b101), 18);
    send("R8 bge both 0",  eb(5'd0, 5'd0, 3'b101), 18);
    send("R11 bltu rs2 0", eb(5'd0, 5'd4, 3'b110), 0);
  endtask

  task automatic t_regop();
    send("R9 neg",         er(7'b0100000, 5'd6, 5'd0, 3'b000, 5'd2, 7'b0110011), 19);
    send("R9 negw",        er(7'b0100000, 5'd6, 5'd0, 3'b000, 5'd2, 7'b0111011), 20);
    send("R9 sub rs1 3",   er(7'b0100000, 5'd6, 5'd3, 3'b000, 5'd2, 7'b0110011), 0);
    send("R9 sltz",        er(7'b0000000, 5'd0, 5'd6, 3'b010, 5'd2, 7'b0110011), 21);
    send("R9 sgtz",        er(7'b0000000, 5'd6, 5'd0, 3'b010, 5'd2, 7'b0110011), 22);
    send("R9 snez",        er(7'b0000000, 5'd6, 5'd0, 3'b011, 5'd2, 7'b0110011), 23);
    send("R9 sltu rs2 0",  er(7'b0000000, 5'd0, 5'd6, 3'b011, 5'd2, 7'b0110011), 0);
    send("R11 add rs1 0",  er(7'b0000000, 5'd6, 5'd0, 3'b000, 5'd2, 7'b0110011), 0);
    send("R11 mul rs1 0",  er(7'b0000001, 5'd6, 5'd0, 3'b000, 5'd2, 7'b0110011), 0);
  endtask

  task automatic t_csr();
    send("R10 csrr",        ecsr(5'd0, 3'b010, 5'd5), 24);
    send("R10 csrr rd0",    ecsr(5'd0, 3'b010, 5'd0), 24);
    send("R10 csrs",        ecsr(5'd3, 3'b010, 5'd0), 26);
    send("R10 csrw",        ecsr(5'd3, 3'b001, 5'd0), 25);
    send("R10 csrc",        ecsr(5'd3, 3'b011, 5'd0), 27);
    send("R10 csrwi",       ecsr(5'd0, 3'b101, 5'd0), 28);
    send("R10 csrsi",       ecsr(5'd0, 3'b110, 5'd0), 29);
    send("R10 csrci",       ecsr(5'd9, 3'b111, 5'd0), 30);
    send("R10 csrrw rd5",   ecsr(5'd3, 3'b001, 5'd5), 0);
    send("R10 csrrsi rd5",  ecsr(5'd0, 3'b110, 5'd5), 0);
  endtask

  task automatic t_unknown();
    send("R11 all ones",    32'hFFFF_FFFF, 0);
    send("R11 load",        32'h0000_2003, 0);
    send("R11 ecall",       32'h0000_0073, 0);
    send("R11 slli",        32'h0000_1013, 0);
  endtask

  task automatic t_stream();
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = ejal(5'd0);
    @(negedge clk);
    check("R1 stream first", out_alias, 11);
    in_insn = eb(5'd0, 5'd4, 3'b001);
    @(negedge clk);
    check("R1 stream second", out_alias, 14);
    check("R1 stream valid", out_valid, 1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 drop valid", out_valid, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_insn   = 32'h0000_0013;
    @(negedge clk);
    check("R2 stall first code", out_alias, 1);
    check("R2 stall ready low", in_ready, 0);
    in_insn = ecsr(5'd3, 3'b011, 5'd0);
    @(negedge clk);
    check("R2 stall held code", out_alias, 1);
    check("R2 stall held valid", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    check("R2 after release", out_alias, 27);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 drained", out_valid, 0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_insn = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_addi();
    t_imm();
    t_fence();
    t_jump();
    t_branch();
    t_regop();
    t_csr();
    t_unknown();
    t_stream();
    t_stall();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule